// File: doc/BRIEF.md
# Graphic LCD Command and Refresh Sequencer

This block owns the 8-bit parallel write bus of a monochrome 240 by 128 dot graphic LCD controller. Out of reset it brings the panel up without software: it pulses the panel reset line low, selects the controller, waits for it to settle and then writes a fixed set of configuration registers. Each register write is two bus bytes. The first is an instruction byte that carries the register index, with register select high. The second is a data byte that carries the value, with register select low.

Once the panel is up, a host asks for one band to be refreshed by pulsing `refresh_req` with a band number. A band is eight display lines of 30 bytes each, and the block streams it from a packed one-bit-per-dot frame buffer into display RAM. The frame buffer is read through a synchronous port with one cycle of read latency. Before each line, the block reloads the display cursor with that line's RAM address and then sends the line's bytes as one burst.

The control state machine has these states: `ST_BOOT`, `ST_RST_LOW`, `ST_PWR_WAIT`, `ST_CFG_SEND`, `ST_CFG_WAIT`, `ST_CFG_SETTLE`, `ST_IDLE`, `ST_CMD_SEND`, `ST_CMD_WAIT`, `ST_DAT_FETCH`, `ST_DAT_SEND`, `ST_DAT_WAIT` and `ST_FINISH`.

The power-up path runs in a fixed order:
- `ST_BOOT` always moves to `ST_RST_LOW` and arms the reset timer.
- `ST_RST_LOW` moves to `ST_PWR_WAIT` when the timer expires.
- `ST_PWR_WAIT` moves to `ST_CFG_SEND` when the timer expires.
- `ST_CFG_SEND` always moves to `ST_CFG_WAIT`.
- `ST_CFG_WAIT` goes back to `ST_CFG_SEND` when a byte completes, or moves to `ST_CFG_SETTLE` after the last configuration byte.
- `ST_CFG_SETTLE` moves to `ST_IDLE` when the timer expires.

A refresh runs in this order:
- `ST_IDLE` moves to `ST_CMD_SEND` on a request with a valid band. A request with an invalid band leaves it in `ST_IDLE` with an error pulse.
- `ST_CMD_SEND` always moves to `ST_CMD_WAIT`.
- `ST_CMD_WAIT` goes back to `ST_CMD_SEND` when a cursor or instruction byte completes. After the fifth byte of the line header it moves to `ST_DAT_FETCH`.
- `ST_DAT_FETCH` always moves to `ST_DAT_SEND`.
- `ST_DAT_SEND` always moves to `ST_DAT_WAIT`.
- `ST_DAT_WAIT` goes back to `ST_DAT_FETCH` for the next byte. After the last byte of a line it goes to `ST_CMD_SEND`. After the last byte of the band it goes to `ST_FINISH`.
- `ST_FINISH` always moves to `ST_IDLE`.

Top module: `lcd_band_sequencer`

## Requirements
- R1: While reset is applied and right after it, `lcd_rst_n` is low, `lcd_cs` is low, `lcd_we_n` is high and `busy` is high. `lcd_rst_n` then stays low for RESET_MS milliseconds (242 by default) with `lcd_cs` low.
- R2: When `lcd_rst_n` rises, `lcd_cs` goes high, and no byte is written for PWRUP_MS milliseconds (50 by default).
- R3: The configuration is written as 12 bytes in this exact order, each shown as register select then value: (1,0x00) (0,0x32) (1,0x01) (0,0x07) (1,0x02) (0,line bytes minus one = 29) (1,0x03) (0,0x7F) (1,0x08) (0,0x00) (1,0x09) (0,0x00). `lcd_cs` then stays high for CFG_MS milliseconds (10 by default) before it falls and `busy` drops.
- R4: Each byte holds `lcd_data` and `lcd_rs` for one cycle before `lcd_we_n` falls. `lcd_we_n` then stays low for exactly WR_PULSE cycles (2 by default) with data and register select unchanged.
- R5: A band refresh writes exactly 8 × 35 = 280 bytes. For each line the order is: (1,0x0A), (0,address low byte), (1,0x0B), (0,address high byte), (1,0x0C), and then 30 data bytes with register select low.
- R6: Line L of band B uses display address B×240 + L×30. Its 30 data bytes are the frame-buffer bytes at that address and the 29 addresses after it, in ascending order.
- R7: `lcd_cs` goes high when the band starts, stays high through all eight lines, and falls exactly once after the last byte. No write strobe ever happens while `lcd_cs` is low.
- R8: `busy` is high during power-up and during a band transfer. A refresh request made while `busy` is high is ignored: it causes no bus bytes and no `band_done` pulse.
- R9: `band_done` pulses high for exactly one cycle when a band ends, and `busy` is low on the next cycle.
- R10: A request with a band number of 16 or more pulses `band_err` for one cycle. It leaves `busy` low and produces no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_req | input | 1 | One-cycle request to refresh a band |
| refresh_band | input | 5 | Band number for the request (0 to 15 are valid) |
| fb_rd_en | output | 1 | Frame-buffer read enable |
| fb_rd_addr | output | 12 | Frame-buffer byte address |
| fb_rd_data | input | 8 | Frame-buffer read data, valid one cycle after `fb_rd_en` |
| lcd_data | output | 8 | LCD data bus |
| lcd_rs | output | 1 | Register select: 1 = instruction byte, 0 = data byte |
| lcd_we_n | output | 1 | Active-low write strobe |
| lcd_cs | output | 1 | Chip select, high = selected |
| lcd_rst_n | output | 1 | Active-low LCD reset |
| busy | output | 1 | High during power-up or a band transfer |
| band_done | output | 1 | One-cycle pulse when a band transfer ends |
| band_err | output | 1 | One-cycle pulse when a request has an out-of-range band |

## Verification
Several rules are checked on every cycle:
- Data and register select are stable over each write strobe, and each strobe has the right width.
- No strobe happens while chip select is low.
- Chip select stays low and `busy` stays high while the panel is held in reset.
- `band_done` lasts one cycle.
- `band_err` never appears while `busy` is high.

Other behaviour only the directed scenarios can show:
- the byte order of the configuration and of each band;
- the cursor address of each line;
- that the bytes sent match the frame-buffer contents;
- the millisecond spacing of power-up;
- that requests made while busy are ignored, and that rejected bands cause no activity.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_RST_LOW,
        ST_PWR_WAIT,
        ST_CFG_SEND,
        ST_CFG_WAIT,
        ST_CFG_SETTLE,
        ST_IDLE,
        ST_CMD_SEND,
        ST_CMD_WAIT,
        ST_DAT_FETCH,
        ST_DAT_SEND,
        ST_DAT_WAIT,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        BW_IDLE,
        BW_SETUP,
        BW_STROBE,
        BW_HOLD
    } bw_state_t;

    typedef struct packed {
        logic       rs;
        logic [7:0] val;
    } bus_byte_t;

    localparam int CFG_LEN  = 12;
    localparam int HDR_LEN  = 5;

    localparam logic [7:0] IDX_MODE     = 8'h00;
    localparam logic [7:0] IDX_PITCH    = 8'h01;
    localparam logic [7:0] IDX_LINE_W   = 8'h02;
    localparam logic [7:0] IDX_DUTY     = 8'h03;
    localparam logic [7:0] IDX_ORG_LO   = 8'h08;
    localparam logic [7:0] IDX_ORG_HI   = 8'h09;
    localparam logic [7:0] IDX_CUR_LO   = 8'h0A;
    localparam logic [7:0] IDX_CUR_HI   = 8'h0B;
    localparam logic [7:0] IDX_RAM_WR   = 8'h0C;

    localparam logic [7:0] VAL_MODE     = 8'h32;
    localparam logic [7:0] VAL_PITCH    = 8'h07;
    localparam logic [7:0] VAL_DUTY     = 8'h7F;

    function automatic bus_byte_t cfg_entry(input logic [3:0] idx,
                                            input logic [7:0] line_m1);
        bus_byte_t b;
        case (idx)
            4'd0:    b = '{rs: 1'b1, val: IDX_MODE};
            4'd1:    b = '{rs: 1'b0, val: VAL_MODE};
            4'd2:    b = '{rs: 1'b1, val: IDX_PITCH};
            4'd3:    b = '{rs: 1'b0, val: VAL_PITCH};
            4'd4:    b = '{rs: 1'b1, val: IDX_LINE_W};
            4'd5:    b = '{rs: 1'b0, val: line_m1};
            4'd6:    b = '{rs: 1'b1, val: IDX_DUTY};
            4'd7:    b = '{rs: 1'b0, val: VAL_DUTY};
            4'd8:    b = '{rs: 1'b1, val: IDX_ORG_LO};
            4'd10:   b = '{rs: 1'b1, val: IDX_ORG_HI};
            default: b = '{rs: 1'b0, val: 8'h00};
        endcase
        return b;
    endfunction

    function automatic bus_byte_t hdr_entry(input logic [2:0]  step,
                                            input logic [15:0] addr);
        bus_byte_t b;
        case (step)
            3'd0:    b = '{rs: 1'b1, val: IDX_CUR_LO};
            3'd1:    b = '{rs: 1'b0, val: addr[7:0]};
            3'd2:    b = '{rs: 1'b1, val: IDX_CUR_HI};
            3'd3:    b = '{rs: 1'b0, val: addr[15:8]};
            default: b = '{rs: 1'b1, val: IDX_RAM_WR};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int MS_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            expire
);
    localparam int CYC_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int PRE_W      = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            ms_q   <= '0;
            run_q  <= 1'b0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (load) begin
                pre_q <= PRE_TOP;
                ms_q  <= load_ms;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (pre_q == '0) begin
                    pre_q <= PRE_TOP;
                    if (ms_q <= MS_W'(1)) begin
                        run_q  <= 1'b0;
                        expire <= 1'b1;
                    end else begin
                        ms_q <= ms_q - MS_W'(1);
                    end
                end else begin
                    pre_q <= pre_q - PRE_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/lcd_byte_writer.sv
module lcd_byte_writer
    import lcd_seq_pkg::*;
#(
    parameter int WR_PULSE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       rs_in,
    input  logic [7:0] data_in,
    output logic [7:0] lcd_data,
    output logic       lcd_rs,
    output logic       lcd_we_n,
    output logic       byte_done
);
    localparam int CNT_W = (WR_PULSE > 1) ? $clog2(WR_PULSE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_PULSE - 1);

    bw_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       data_q;
    logic             rs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BW_IDLE;
            cnt_q   <= '0;
            data_q  <= '0;
            rs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == BW_IDLE && go) begin
                data_q <= data_in;
                rs_q   <= rs_in;
            end
            if (state_q == BW_STROBE) cnt_q <= cnt_q + CNT_W'(1);
            else                      cnt_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BW_IDLE:   if (go) state_d = BW_SETUP;
            BW_SETUP:  state_d = BW_STROBE;
            BW_STROBE: if (cnt_q == CNT_LAST) state_d = BW_HOLD;
            BW_HOLD:   state_d = BW_IDLE;
            default:   state_d = BW_IDLE;
        endcase
    end

    always_comb begin
        lcd_data  = data_q;
        lcd_rs    = rs_q;
        lcd_we_n  = (state_q != BW_STROBE);
        byte_done = (state_q == BW_HOLD);
    end
endmodule

// File: rtl/lcd_row_cursor.sv
module lcd_row_cursor #(
    parameter int LINE_BYTES = 30,
    parameter int BAND_LINES = 8,
    parameter int FB_AW      = 12,
    parameter int BAND_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BAND_W-1:0] band,
    input  logic              line_adv,
    input  logic              byte_adv,
    output logic [FB_AW-1:0]  row_addr,
    output logic [FB_AW-1:0]  rd_addr,
    output logic              last_byte,
    output logic              last_line
);
    localparam int BIDX_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;
    localparam int LINE_W = (BAND_LINES > 1) ? $clog2(BAND_LINES) : 1;
    localparam logic [FB_AW-1:0] BAND_BYTES = FB_AW'(LINE_BYTES * BAND_LINES);
    localparam logic [FB_AW-1:0] LINE_STEP  = FB_AW'(LINE_BYTES);

    logic [FB_AW-1:0]  base_q;
    logic [BIDX_W-1:0] bidx_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            bidx_q <= '0;
            line_q <= '0;
        end else if (load) begin
            base_q <= FB_AW'(band) * BAND_BYTES;
            bidx_q <= '0;
            line_q <= '0;
        end else if (line_adv) begin
            base_q <= base_q + LINE_STEP;
            bidx_q <= '0;
            line_q <= line_q + LINE_W'(1);
        end else if (byte_adv) begin
            bidx_q <= bidx_q + BIDX_W'(1);
        end
    end

    always_comb begin
        row_addr  = base_q;
        rd_addr   = base_q + FB_AW'(bidx_q);
        last_byte = (bidx_q == BIDX_W'(LINE_BYTES - 1));
        last_line = (line_q == LINE_W'(BAND_LINES - 1));
    end
endmodule

// File: rtl/lcd_band_sequencer.sv
module lcd_band_sequencer
    import lcd_seq_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int WR_PULSE   = 2,
    parameter int RESET_MS   = 242,
    parameter int PWRUP_MS   = 50,
    parameter int CFG_MS     = 10,
    parameter int H_DOTS     = 240,
    parameter int V_DOTS     = 128,
    parameter int BAND_LINES = 8,
    localparam int LINE_BYTES = H_DOTS / 8,
    localparam int NUM_BANDS  = V_DOTS / BAND_LINES,
    localparam int FB_AW      = $clog2(LINE_BYTES * V_DOTS),
    localparam int BAND_W     = $clog2(NUM_BANDS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_req,
    input  logic [BAND_W-1:0] refresh_band,
    output logic              fb_rd_en,
    output logic [FB_AW-1:0]  fb_rd_addr,
    input  logic [7:0]        fb_rd_data,
    output logic [7:0]        lcd_data,
    output logic              lcd_rs,
    output logic              lcd_we_n,
    output logic              lcd_cs,
    output logic              lcd_rst_n,
    output logic              busy,
    output logic              band_done,
    output logic              band_err
);
    localparam int MS_MAX0 = (RESET_MS > PWRUP_MS) ? RESET_MS : PWRUP_MS;
    localparam int MS_MAX  = (MS_MAX0 > CFG_MS) ? MS_MAX0 : CFG_MS;
    localparam int MS_W    = $clog2(MS_MAX + 1);
    localparam logic [7:0] LINE_M1 = 8'(LINE_BYTES - 1);
    localparam logic [BAND_W-1:0] BAND_LIMIT = BAND_W'(NUM_BANDS);

    seq_state_t        state_q, state_d;
    logic [3:0]        cfg_idx_q;
    logic [2:0]        hdr_step_q;
    logic              err_q;

    logic              tmr_load, tmr_expire;
    logic [MS_W-1:0]   tmr_ms;
    logic              bw_go, bw_rs, bw_done;
    logic [7:0]        bw_data;
    logic              cur_load, cur_line_adv, cur_byte_adv;
    logic              cur_last_byte, cur_last_line;
    logic [FB_AW-1:0]  row_addr;
    logic              req_ok, req_bad;
    bus_byte_t         cfg_b, hdr_b;

    assign req_ok  = refresh_req && (refresh_band <  BAND_LIMIT);
    assign req_bad = refresh_req && (refresh_band >= BAND_LIMIT);
    assign cfg_b   = cfg_entry(cfg_idx_q, LINE_M1);
    assign hdr_b   = hdr_entry(hdr_step_q, 16'(row_addr));

    lcd_ms_timer #(.CLK_HZ(CLK_HZ), .MS_W(MS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_ms (tmr_ms),
        .expire  (tmr_expire)
    );

    lcd_byte_writer #(.WR_PULSE(WR_PULSE)) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (bw_go),
        .rs_in     (bw_rs),
        .data_in   (bw_data),
        .lcd_data  (lcd_data),
        .lcd_rs    (lcd_rs),
        .lcd_we_n  (lcd_we_n),
        .byte_done (bw_done)
    );

    lcd_row_cursor #(
        .LINE_BYTES (LINE_BYTES),
        .BAND_LINES (BAND_LINES),
        .FB_AW      (FB_AW),
        .BAND_W     (BAND_W)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cur_load),
        .band      (refresh_band),
        .line_adv  (cur_line_adv),
        .byte_adv  (cur_byte_adv),
        .row_addr  (row_addr),
        .rd_addr   (fb_rd_addr),
        .last_byte (cur_last_byte),
        .last_line (cur_last_line)
    );

    // state register and step counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_BOOT;
            cfg_idx_q  <= '0;
            hdr_step_q <= '0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= (state_q == ST_IDLE) && req_bad;
            if (state_q == ST_PWR_WAIT)
                cfg_idx_q <= '0;
            else if (state_q == ST_CFG_WAIT && bw_done)
                cfg_idx_q <= cfg_idx_q + 4'd1;
            if (state_q == ST_IDLE || state_q == ST_DAT_WAIT)
                hdr_step_q <= '0;
            else if (state_q == ST_CMD_WAIT && bw_done)
                hdr_step_q <= hdr_step_q + 3'd1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:       state_d = ST_RST_LOW;
            ST_RST_LOW:    if (tmr_expire) state_d = ST_PWR_WAIT;
            ST_PWR_WAIT:   if (tmr_expire) state_d = ST_CFG_SEND;
            ST_CFG_SEND:   state_d = ST_CFG_WAIT;
            ST_CFG_WAIT:   if (bw_done)
                               state_d = (cfg_idx_q == 4'(CFG_LEN - 1)) ? ST_CFG_SETTLE
                                                                       : ST_CFG_SEND;
            ST_CFG_SETTLE: if (tmr_expire) state_d = ST_IDLE;
            ST_IDLE:       if (req_ok) state_d = ST_CMD_SEND;
            ST_CMD_SEND:   state_d = ST_CMD_WAIT;
            ST_CMD_WAIT:   if (bw_done)
                               state_d = (hdr_step_q == 3'(HDR_LEN - 1)) ? ST_DAT_FETCH
                                                                        : ST_CMD_SEND;
            ST_DAT_FETCH:  state_d = ST_DAT_SEND;
            ST_DAT_SEND:   state_d = ST_DAT_WAIT;
            ST_DAT_WAIT:   if (bw_done) begin
                               if (!cur_last_byte)     state_d = ST_DAT_FETCH;
                               else if (cur_last_line) state_d = ST_FINISH;
                               else                    state_d = ST_CMD_SEND;
                           end
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_BOOT;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        lcd_rst_n    = 1'b1;
        lcd_cs       = 1'b1;
        busy         = 1'b1;
        band_done    = 1'b0;
        band_err     = err_q;
        fb_rd_en     = 1'b0;
        tmr_load     = 1'b0;
        tmr_ms       = '0;
        bw_go        = 1'b0;
        bw_rs        = 1'b0;
        bw_data      = '0;
        cur_load     = 1'b0;
        cur_line_adv = 1'b0;
        cur_byte_adv = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                lcd_rst_n = 1'b0;
                lcd_cs    = 1'b0;
                tmr_load  = 1'b1;
                tmr_ms    = MS_W'(RESET_MS);
            end
            ST_RST_LOW: begin
                lcd_rst_n = 1'b0;
                lcd_cs    = 1'b0;
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    tmr_ms   = MS_W'(PWRUP_MS);
                end
            end
            ST_PWR_WAIT: ;
            ST_CFG_SEND: begin
                bw_go   = 1'b1;
                bw_rs   = cfg_b.rs;
                bw_data = cfg_b.val;
            end
            ST_CFG_WAIT: begin
                if (bw_done && cfg_idx_q == 4'(CFG_LEN - 1)) begin
                    tmr_load = 1'b1;
                    tmr_ms   = MS_W'(CFG_MS);
                end
            end
            ST_CFG_SETTLE: ;
            ST_IDLE: begin
                lcd_cs   = 1'b0;
                busy     = 1'b0;
                cur_load = req_ok;
            end
            ST_CMD_SEND: begin
                bw_go   = 1'b1;
                bw_rs   = hdr_b.rs;
                bw_data = hdr_b.val;
            end
            ST_CMD_WAIT: ;
            ST_DAT_FETCH: fb_rd_en = 1'b1;
            ST_DAT_SEND: begin
                bw_go   = 1'b1;
                bw_rs   = 1'b0;
                bw_data = fb_rd_data;
            end
            ST_DAT_WAIT: begin
                if (bw_done) begin
                    cur_byte_adv = !cur_last_byte;
                    cur_line_adv = cur_last_byte && !cur_last_line;
                end
            end
            ST_FINISH: begin
                lcd_cs    = 1'b0;
                band_done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lcd_seq_checker.sv
module lcd_seq_checker #(
    parameter int WR_PULSE = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] lcd_data,
    input logic       lcd_rs,
    input logic       lcd_we_n,
    input logic       lcd_cs,
    input logic       lcd_rst_n,
    input logic       busy,
    input logic       band_done,
    input logic       band_err
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)         low_cnt <= '0;
        else if (!lcd_we_n) low_cnt <= low_cnt + 16'd1;
        else                low_cnt <= '0;
    end

    // R4: setup cycle before the strobe falls
    a_r4_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_we_n) |-> $stable(lcd_data) && $stable(lcd_rs));

    // R4: bus stays unchanged while the strobe is low
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_we_n && $past(!lcd_we_n)) |-> $stable(lcd_data) && $stable(lcd_rs));

    // R4: strobe width
    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_we_n) |-> low_cnt == 16'(WR_PULSE));

    // R7: no strobe while deselected
    a_r7_cs_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_we_n |-> lcd_cs);

    // R1: panel held in reset only while deselected during power-up
    a_r1_reset_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> !lcd_cs && busy);

    // R9: done is a single-cycle pulse followed by idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        band_done |=> !band_done && !busy);

    // R10: rejected requests only while idle
    a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        band_err |-> !busy && lcd_we_n);
endmodule

bind lcd_band_sequencer lcd_seq_checker #(.WR_PULSE(WR_PULSE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lcd_data  (lcd_data),
    .lcd_rs    (lcd_rs),
    .lcd_we_n  (lcd_we_n),
    .lcd_cs    (lcd_cs),
    .lcd_rst_n (lcd_rst_n),
    .busy      (busy),
    .band_done (band_done),
    .band_err  (band_err)
);

// File: tb/sim_lcd_band_sequencer.sv
module sim_lcd_band_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int SIM_HZ     = 4000;
    localparam int CPM        = SIM_HZ / 1000;
    localparam int WR         = 2;
    localparam int LOG_MAX    = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        refresh_req = 1'b0;
    logic [4:0]  refresh_band = '0;
    logic        fb_rd_en;
    logic [11:0] fb_rd_addr;
    logic [7:0]  fb_rd_data = '0;
    logic [7:0]  lcd_data;
    logic        lcd_rs, lcd_we_n, lcd_cs, lcd_rst_n;
    logic        busy, band_done, band_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_band_sequencer #(.CLK_HZ(SIM_HZ), .WR_PULSE(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .refresh_band(refresh_band),
        .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
        .lcd_data(lcd_data), .lcd_rs(lcd_rs), .lcd_we_n(lcd_we_n), .lcd_cs(lcd_cs),
        .lcd_rst_n(lcd_rst_n), .busy(busy), .band_done(band_done), .band_err(band_err)
    );

    function automatic logic [7:0] fbval(input int a);
        return 8'((a * 37 + (a >> 8) + 11) & 255);
    endfunction

    always @(posedge clk) if (fb_rd_en) fb_rd_data <= fbval(int'(fb_rd_addr));

    // bus monitor
    logic [8:0] wlog [0:LOG_MAX-1];
    int   log_n = 0, cyc = 0, rst_low = 0, low_len = 0;
    int   t_rst_rise = -1, t_first_we = -1, t_last_rise = -1, t_cs_fall = -1;
    int   bad_setup = 0, bad_width = 0, bad_cs = 0, cs_falls = 0, done_n = 0, err_n = 0;
    logic prev_we = 1'b1, prev_cs = 1'b0, prev_rst = 1'b0;
    logic [8:0] prev_bus = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!lcd_rst_n) rst_low++;
            if (lcd_rst_n && !prev_rst && t_rst_rise < 0) t_rst_rise = cyc;
            if (prev_we && !lcd_we_n) begin
                if (log_n < LOG_MAX) wlog[log_n] = {lcd_rs, lcd_data};
                log_n++;
                if (t_first_we < 0) t_first_we = cyc;
                if ({lcd_rs, lcd_data} != prev_bus) bad_setup++;
                if (!lcd_cs) bad_cs++;
                low_len = 1;
            end else if (!lcd_we_n) begin
                low_len++;
                if ({lcd_rs, lcd_data} != prev_bus) bad_setup++;
            end
            if (lcd_we_n && !prev_we) begin
                if (low_len != WR) bad_width++;
                t_last_rise = cyc;
            end
            if (!lcd_cs && prev_cs) begin
                cs_falls++;
                t_cs_fall = cyc;
            end
            if (band_done) done_n++;
            if (band_err)  err_n++;
        end
        prev_we  = lcd_we_n;
        prev_cs  = lcd_cs;
        prev_rst = lcd_rst_n;
        prev_bus = {lcd_rs, lcd_data};
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic pulse_req(input int band);
        @(negedge clk);
        refresh_req  = 1'b1;
        refresh_band = 5'(band);
        @(negedge clk);
        refresh_req  = 1'b0;
    endtask

    // R5 / R6: compare the logged bytes of one band, one check per line
    task automatic verify_band(input int base, input int band);
        for (int ln = 0; ln < 8; ln++) begin
            int addr = band * 240 + ln * 30;
            int p = base + ln * 35;
            int bad = 0;
            int first_act = 0, first_exp = 0;
            logic [8:0] exp_b [0:34];
            exp_b[0] = {1'b1, 8'h0A};
            exp_b[1] = {1'b0, 8'(addr & 255)};
            exp_b[2] = {1'b1, 8'h0B};
            exp_b[3] = {1'b0, 8'(addr >> 8)};
            exp_b[4] = {1'b1, 8'h0C};
            for (int k = 0; k < 30; k++) exp_b[5 + k] = {1'b0, fbval(addr + k)};
            for (int k = 0; k < 35; k++) begin
                if (p + k < LOG_MAX && wlog[p + k] != exp_b[k]) begin
                    if (bad == 0) begin
                        first_act = int'(wlog[p + k]);
                        first_exp = int'(exp_b[k]);
                    end
                    bad++;
                end
            end
            checks++;
            if (bad != 0) begin
                errors++;
                $display("FAIL R5/R6 band %0d line %0d actual=%0h expected=%0h", band, ln,
                         first_act, first_exp);
            end
        end
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        chk("R1 reset lcd_rst_n", int'(lcd_rst_n), 0);
        chk("R1 reset lcd_cs", int'(lcd_cs), 0);
        chk("R1 reset lcd_we_n", int'(lcd_we_n), 1);
        chk("R1 reset busy", int'(busy), 1);
        chk("R9 reset band_done", int'(band_done), 0);
    endtask

    task automatic test_init();
        logic [8:0] cfg [0:11];
        cfg = '{9'h100, 9'h032, 9'h101, 9'h007, 9'h102, 9'h01D,
                9'h103, 9'h07F, 9'h108, 9'h000, 9'h109, 9'h000};
        repeat (20) @(negedge clk);
        pulse_req(1);                      // R8: ignored during power-up
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk_rng("R1 reset low cycles", rst_low, 242 * CPM, 242 * CPM + 8);
        chk_rng("R2 power-up gap", t_first_we - t_rst_rise, 50 * CPM, 50 * CPM + 10);
        chk("R3 config byte count", log_n, 12);
        for (int i = 0; i < 12; i++) chk("R3 config byte", int'(wlog[i]), int'(cfg[i]));
        chk_rng("R3 settle before deselect", t_cs_fall - t_last_rise, 10 * CPM, 10 * CPM + 10);
        chk("R8 request during power-up ignored", done_n, 0);
        chk("R4 setup/hold violations", bad_setup, 0);
        chk("R4 strobe width violations", bad_width, 0);
    endtask

    task automatic test_band(input int band);
        int base = log_n, d0 = done_n, c0 = cs_falls;
        pulse_req(band);
        chk("R8 busy after request", int'(busy), 1);
        chk("R7 cs high at band start", int'(lcd_cs), 1);
        while (!band_done) @(negedge clk);
        @(negedge clk);
        chk("R9 done single cycle", int'(band_done), 0);
        chk("R9 idle after done", int'(busy), 0);
        chk("R5 band byte count", log_n - base, 280);
        chk("R7 single cs release", cs_falls - c0, 1);
        chk("R9 one done pulse", done_n - d0, 1);
        chk("R7 writes while deselected", bad_cs, 0);
        chk("R4 strobe width violations", bad_width, 0);
        verify_band(base, band);
    endtask

    task automatic test_bad_band(input int band);
        int base = log_n, e0 = err_n;
        @(negedge clk);
        refresh_req  = 1'b1;
        refresh_band = 5'(band);
        @(negedge clk);
        refresh_req  = 1'b0;
        chk("R10 error pulse", int'(band_err), 1);
        chk("R10 stays idle", int'(busy), 0);
        repeat (50) @(negedge clk);
        chk("R10 no bus bytes", log_n - base, 0);
        chk("R10 one error pulse", err_n - e0, 1);
        chk("R10 still idle", int'(busy), 0);
    endtask

    task automatic test_busy_ignore();
        int base = log_n, d0 = done_n;
        pulse_req(2);
        repeat (30) @(negedge clk);
        chk("R8 busy mid-band", int'(busy), 1);
        pulse_req(5);
        while (!band_done) @(negedge clk);
        repeat (3000) @(negedge clk);
        chk("R8 ignored request adds no bytes", log_n - base, 280);
        chk("R8 ignored request adds no done", done_n - d0, 1);
        verify_band(base, 2);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset_state();
        rst_n = 1'b1;
        test_init();
        test_band(0);
        test_band(15);
        test_band(7);
        test_bad_band(16);
        test_bad_band(31);
        test_busy_ignore();
        summary();
        $finish;
    end
endmodule